// File: doc/BRIEF.md
# Fused multiply-add NaN selector

This block decides what a fused multiply-add of the form (a*b)+c returns when one or more of its three single-precision operands is a NaN. Each operand is classified as zero, infinity, ordinary (normal or subnormal), quiet NaN or signalling NaN. A two-bit policy select then chooses one of four NaN-priority orderings. The block either forwards the winning operand's NaN in quieted form or produces the canonical default NaN. It also reports an invalid-operation flag.

A polarity input reverses the meaning of the top fraction bit, so that a set bit marks a signalling NaN rather than a quiet one. A default-NaN-mode input replaces the forwarded NaN with the canonical one after the selection has been made. The arithmetic datapath, rounding and subnormal handling belong to the surrounding unit.

Selection is combinational. Its result is registered once: a request sampled with `in_valid` high appears on the outputs on the next cycle, together with `out_valid`.

Top module: `fma_nan_pick`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero; when `snan_inv` is 0 a NaN with bit 22 set is quiet and one with bit 22 clear is signalling, and when `snan_inv` is 1 the two meanings swap.
- R2: Reset is synchronous and active low and clears every output to zero; `out_valid` is `in_valid` delayed by one cycle, and the data outputs change only on a cycle after `in_valid` was sampled high.
- R3: `out_choice` codes are 0 for a, 1 for b, 2 for c and 3 for the default NaN; with no NaN operand `out_hit` is 0 and `out_choice`, `out_result` and `out_invalid` are all 0, even for infinity times zero.
- R4: Policy 0 takes the first match among signalling c, signalling a, signalling b, quiet c, quiet a, and otherwise b.
- R5: In policies 0 and 1 (both polarities), when one of a and b is infinity, the other is zero and c is a quiet NaN, the choice is 3 and invalid is raised.
- R6: Policy 1 with `snan_inv` = 1 takes the first match among signalling a, signalling b, signalling c, quiet a, quiet b, and otherwise c.
- R7: Policy 1 with `snan_inv` = 0 uses the same ordering as policy 0.
- R8: Policy 2 picks a if a is any NaN, else c if c is any NaN, else b; infinity times zero with a NaN c still forwards c and raises invalid.
- R9: Policy 3 picks a if a is any NaN, else b if b is any NaN, else c.
- R10: When a NaN is present, `out_invalid` is 1 if any operand is a signalling NaN or if one of a and b is infinity and the other is zero; otherwise it is 0.
- R11: The forwarded NaN keeps its sign and payload, with bit 22 forced to 1 when `snan_inv` is 0 or forced to 0 when it is 1; if forcing bit 22 to 0 leaves a zero fraction, the default NaN is output instead.
- R12: The default NaN is 0x7FC00000 when `snan_inv` is 0 and 0x7FBFFFFF when it is 1.
- R13: With `dflt_mode` = 1 and a NaN present, `out_result` is the default NaN while `out_choice` and `out_invalid` still report the selection; with no NaN present `dflt_mode` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands and controls are sampled when high |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| op_c | input | 32 | Addend |
| policy | input | 2 | NaN-priority policy select, 0 to 3 |
| snan_inv | input | 1 | 1 means bit 22 set marks a signalling NaN |
| dflt_mode | input | 1 | Replace any forwarded NaN with the default NaN |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| out_hit | output | 1 | At least one operand was a NaN |
| out_choice | output | 2 | Selected source: 0 a, 1 b, 2 c, 3 default NaN |
| out_result | output | 32 | Quieted NaN or default NaN |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The bench targets the places where the orderings disagree: a signalling NaN in b against a quiet NaN in c, all three operands signalling, and infinity times zero with a quiet or a signalling c. A design that flattened the signalling-before-quiet ranking would return c where b is expected, and one that ignored the product special case would forward c instead of the default NaN. Under the reversed polarity it checks that quieting clears bit 22, and that a NaN whose only fraction bit is bit 22 becomes the default NaN rather than infinity. It also checks that default-NaN mode changes only the result, not the choice or the flag, and that operands without a NaN, infinity times zero included, leave every output at zero.

// File: rtl/fnp_pkg.sv
// Package for the fused multiply-add NaN selector.
// Holds the operand class type, the choice codes and the operand count.
// Assumes nothing beyond the port encodings given in the brief.
package fnp_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_INF  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_cls_e;

    localparam logic [1:0] PICK_A    = 2'd0;
    localparam logic [1:0] PICK_B    = 2'd1;
    localparam logic [1:0] PICK_C    = 2'd2;
    localparam logic [1:0] PICK_DFLT = 2'd3;

    localparam int N_OPS = 3;

endpackage

// File: rtl/fnp_classify.sv
// Operand classifier: sorts one operand without its sign bit into zero, infinity,
// ordinary, quiet NaN or signalling NaN.
// Assumes the top fraction bit carries the quiet/signalling mark, with its
// meaning reversed when inv is high. Subnormals count as ordinary.
module fnp_classify
    import fnp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int MAG_W = EXP_W + FRAC_W
) (
    input  logic [MAG_W-1:0] mag,
    input  logic             inv,
    output fp_cls_e          cls
);

    localparam int MARK = FRAC_W - 1;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo = mag[MAG_W-1 -: EXP_W];
    assign frac = mag[FRAC_W-1:0];

    // Decode the class from the exponent and fraction fields.
    always_comb begin
        if (&expo) begin
            if (frac == '0)
                cls = CLS_INF;
            else if (frac[MARK] ^ inv)
                cls = CLS_QNAN;
            else
                cls = CLS_SNAN;
        end else if (expo == '0 && frac == '0) begin
            cls = CLS_ZERO;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fnp_priority.sv
// NaN-priority selector: from three operand classes, the policy and the polarity,
// computes the choice code, whether any NaN is present and the invalid flag.
// Assumes the classes come from the classifier driven with the same polarity.
module fnp_priority
    import fnp_pkg::*;
(
    input  fp_cls_e    cls_a,
    input  fp_cls_e    cls_b,
    input  fp_cls_e    cls_c,
    input  logic [1:0] policy,
    input  logic       inv,
    output logic [1:0] pick,
    output logic       hit,
    output logic       invalid
);

    logic sig_a, sig_b, sig_c, qui_a, qui_b, qui_c;
    logic nan_a, nan_b, nan_c, inf_zero;
    logic [1:0] p_cab, p_abc, p_ac, p_ab;

    // Per-operand flags and the infinity-times-zero product case.
    always_comb begin
        sig_a    = (cls_a == CLS_SNAN);
        sig_b    = (cls_b == CLS_SNAN);
        sig_c    = (cls_c == CLS_SNAN);
        qui_a    = (cls_a == CLS_QNAN);
        qui_b    = (cls_b == CLS_QNAN);
        qui_c    = (cls_c == CLS_QNAN);
        nan_a    = sig_a | qui_a;
        nan_b    = sig_b | qui_b;
        nan_c    = sig_c | qui_c;
        inf_zero = (cls_a == CLS_INF && cls_b == CLS_ZERO) ||
                   (cls_a == CLS_ZERO && cls_b == CLS_INF);
        hit      = nan_a | nan_b | nan_c;
        invalid  = hit & (sig_a | sig_b | sig_c | inf_zero);
    end

    // Candidate choices, one per ordering, evaluated in parallel.
    always_comb begin
        if (sig_c)      p_cab = PICK_C;
        else if (sig_a) p_cab = PICK_A;
        else if (sig_b) p_cab = PICK_B;
        else if (qui_c) p_cab = PICK_C;
        else if (qui_a) p_cab = PICK_A;
        else            p_cab = PICK_B;

        if (sig_a)      p_abc = PICK_A;
        else if (sig_b) p_abc = PICK_B;
        else if (sig_c) p_abc = PICK_C;
        else if (qui_a) p_abc = PICK_A;
        else if (qui_b) p_abc = PICK_B;
        else            p_abc = PICK_C;

        p_ac = nan_a ? PICK_A : (nan_c ? PICK_C : PICK_B);
        p_ab = nan_a ? PICK_A : (nan_b ? PICK_B : PICK_C);
    end

    // Policy mux, then the default-NaN special case, then the no-NaN case.
    always_comb begin
        case (policy)
            2'd0:    pick = p_cab;
            2'd1:    pick = inv ? p_abc : p_cab;
            2'd2:    pick = p_ac;
            default: pick = p_ab;
        endcase
        if (!policy[1] && inf_zero && qui_c)
            pick = PICK_DFLT;
        if (!hit)
            pick = PICK_A;
    end

endmodule

// File: rtl/fnp_quiet.sv
// Result former: picks the chosen operand, sets or clears its quiet mark by
// polarity, and substitutes the default NaN where the rules require it.
// Assumes pick and hit come from the priority selector for the same operands.
module fnp_quiet
    import fnp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic [W-1:0] val_c,
    input  logic [1:0]   pick,
    input  logic         hit,
    input  logic         inv,
    input  logic         dflt_mode,
    output logic [W-1:0] result
);

    localparam logic [W-1:0] MARK_BIT = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] DN_NORM  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] DN_INV   = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    logic [W-1:0] dnan, chosen, quieted;

    // Choose the source value and force its quiet mark.
    always_comb begin
        dnan = inv ? DN_INV : DN_NORM;
        case (pick)
            PICK_A:  chosen = val_a;
            PICK_B:  chosen = val_b;
            PICK_C:  chosen = val_c;
            default: chosen = dnan;
        endcase
        quieted = inv ? (chosen & ~MARK_BIT) : (chosen | MARK_BIT);
    end

    // Final result with the default-NaN substitutions.
    always_comb begin
        if (!hit)
            result = '0;
        else if (dflt_mode || pick == PICK_DFLT || quieted[FRAC_W-1:0] == '0)
            result = dnan;
        else
            result = quieted;
    end

endmodule

// File: rtl/fma_nan_pick.sv
// Fused multiply-add NaN selector, top level. Classifies the three operands,
// selects the NaN source under the chosen policy, forms the quieted result and
// registers it one cycle after in_valid. Assumes single-cycle requests with no
// back-pressure; synchronous active-low reset.
module fma_nan_pick
    import fnp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    input  logic [1:0]   policy,
    input  logic         snan_inv,
    input  logic         dflt_mode,
    output logic         out_valid,
    output logic         out_hit,
    output logic [1:0]   out_choice,
    output logic [W-1:0] out_result,
    output logic         out_invalid
);

    logic [W-1:0] ops [N_OPS];
    fp_cls_e      cls [N_OPS];
    logic [1:0]   sel_code;
    logic         sel_hit, sel_invalid;
    logic [W-1:0] sel_result;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar k = 0; k < N_OPS; k++) begin : g_cls
        fnp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .mag (ops[k][W-2:0]),
            .inv (snan_inv),
            .cls (cls[k])
        );
    end

    fnp_priority u_pri (
        .cls_a   (cls[0]),
        .cls_b   (cls[1]),
        .cls_c   (cls[2]),
        .policy  (policy),
        .inv     (snan_inv),
        .pick    (sel_code),
        .hit     (sel_hit),
        .invalid (sel_invalid)
    );

    fnp_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
        .val_a     (op_a),
        .val_b     (op_b),
        .val_c     (op_c),
        .pick      (sel_code),
        .hit       (sel_hit),
        .inv       (snan_inv),
        .dflt_mode (dflt_mode),
        .result    (sel_result)
    );

    // Output stage: valid follows in_valid; data is captured only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_hit     <= 1'b0;
            out_choice  <= '0;
            out_result  <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_hit     <= sel_hit;
                out_choice  <= sel_code;
                out_result  <= sel_result;
                out_invalid <= sel_invalid;
            end
        end
    end

    logic any_sig;
    assign any_sig = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN) || (cls[2] == CLS_SNAN);

    // R2: valid is the request delayed by one cycle.
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: data holds without a request.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_choice) && $stable(out_invalid));
    // R10: a signalling operand always raises invalid.
    a_r10_sig_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && any_sig |=> out_invalid);
    // R11: a reported NaN result is always a NaN encoding.
    a_r11_result_nan: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_hit |-> (&out_result[W-2 -: EXP_W]) && (|out_result[FRAC_W-1:0]));
    // R5: the default-NaN code arises only under policies 0 and 1.
    a_r5_dflt_policy: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sel_code == PICK_DFLT |-> !policy[1]);
    // R3: without a NaN every data output is zero.
    a_r3_no_nan: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_hit |-> out_result == '0 && !out_invalid && out_choice == PICK_A);

endmodule

// File: tb/test_fma_nan_pick.sv
`timescale 1ns/1ps
module test_fma_nan_pick;

    typedef struct packed {
        logic [31:0] a, b, c;
        logic [1:0]  pol;
        logic        inv, dm, hit;
        logic [1:0]  ch;
        logic [31:0] res;
        logic        iv;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] ONE = 32'h3F800000, PINF = 32'h7F800000, ZRO = 32'h0;
    // H_x: bit 22 set (quiet at normal polarity); L_x: bit 22 clear.
    localparam logic [31:0] HA = 32'h7FC0000A, HB = 32'h7FC0000B, HC = 32'h7FC0000C;
    localparam logic [31:0] LA = 32'h7F80000A, LB = 32'h7F80000B, LC = 32'h7F80000C;
    localparam logic [31:0] DN = 32'h7FC00000, DNI = 32'h7FBFFFFF;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{ONE, ONE, ONE, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 4'd3},  // R3
        '{HA, HB, HC, 2'd0, 1'b0, 1'b0, 1'b1, 2'd2, HC, 1'b0, 4'd4},        // R4
        '{HA, HB, ONE, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, HA, 1'b0, 4'd4},       // R4
        '{ONE, HB, ONE, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, HB, 1'b0, 4'd4},      // R4
        '{HA, LB, HC, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, HB, 1'b1, 4'd4},        // R4
        '{LA, LB, HC, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, HA, 1'b1, 4'd4},        // R4
        '{LA, LB, LC, 2'd0, 1'b0, 1'b0, 1'b1, 2'd2, HC, 1'b1, 4'd10},       // R10
        '{PINF, ZRO, HC, 2'd0, 1'b0, 1'b0, 1'b1, 2'd3, DN, 1'b1, 4'd5},     // R5
        '{ZRO, PINF, LC, 2'd0, 1'b0, 1'b0, 1'b1, 2'd2, HC, 1'b1, 4'd5},     // R5
        '{PINF, ONE, HC, 2'd0, 1'b0, 1'b0, 1'b1, 2'd2, HC, 1'b0, 4'd5},     // R5
        '{HA, LB, HC, 2'd1, 1'b0, 1'b0, 1'b1, 2'd1, HB, 1'b1, 4'd7},        // R7
        '{HA, HB, ONE, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, HA, 1'b0, 4'd7},       // R7
        '{PINF, ZRO, HC, 2'd1, 1'b0, 1'b0, 1'b1, 2'd3, DN, 1'b1, 4'd5},     // R5
        '{LA, HB, HC, 2'd1, 1'b1, 1'b0, 1'b1, 2'd1, LB, 1'b1, 4'd6},        // R6
        '{LA, LB, LC, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, LA, 1'b0, 4'd6},        // R6
        '{ONE, LB, LC, 2'd1, 1'b1, 1'b0, 1'b1, 2'd1, LB, 1'b0, 4'd6},       // R6
        '{ONE, ONE, LC, 2'd1, 1'b1, 1'b0, 1'b1, 2'd2, LC, 1'b0, 4'd6},      // R6
        '{PINF, ZRO, LC, 2'd1, 1'b1, 1'b0, 1'b1, 2'd3, DNI, 1'b1, 4'd12},   // R12
        '{ONE, HB, HC, 2'd2, 1'b0, 1'b0, 1'b1, 2'd2, HC, 1'b0, 4'd8},       // R8
        '{ONE, LB, HC, 2'd2, 1'b0, 1'b0, 1'b1, 2'd2, HC, 1'b1, 4'd8},       // R8
        '{HA, LB, LC, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, HA, 1'b1, 4'd8},        // R8
        '{PINF, ZRO, HC, 2'd2, 1'b0, 1'b0, 1'b1, 2'd2, HC, 1'b1, 4'd8},     // R8
        '{ONE, HB, HC, 2'd3, 1'b0, 1'b0, 1'b1, 2'd1, HB, 1'b0, 4'd9},       // R9
        '{ONE, ONE, LC, 2'd3, 1'b0, 1'b0, 1'b1, 2'd2, HC, 1'b1, 4'd9},      // R9
        '{LA, HB, HC, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, HA, 1'b1, 4'd9},        // R9
        '{DN, ONE, ONE, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, DNI, 1'b1, 4'd11},    // R11
        '{HA, ONE, LC, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, LA, 1'b1, 4'd11},      // R11, R1
        '{HA, LB, HC, 2'd0, 1'b0, 1'b1, 1'b1, 2'd1, DN, 1'b1, 4'd13},       // R13
        '{LA, ONE, ONE, 2'd3, 1'b1, 1'b1, 1'b1, 2'd0, DNI, 1'b0, 4'd13},    // R13
        '{32'hFFC0000A, ONE, ONE, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 32'hFFC0000A, 1'b0, 4'd11}, // R11
        '{PINF, ZRO, ONE, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 4'd3}, // R3
        '{ONE, ONE, ONE, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0, 4'd13}  // R13
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic [1:0]  policy = '0;
    logic        snan_inv = 1'b0, dflt_mode = 1'b0;
    logic        out_valid, out_hit, out_invalid;
    logic [1:0]  out_choice;
    logic [31:0] out_result;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fma_nan_pick i_fma_nan_pick (
        .clk, .rst_n, .in_valid, .op_a, .op_b, .op_c, .policy, .snan_inv,
        .dflt_mode, .out_valid, .out_hit, .out_choice, .out_result, .out_invalid
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid  = 1'b1;
        op_a      = v.a;
        op_b      = v.b;
        op_c      = v.c;
        policy    = v.pol;
        snan_inv  = v.inv;
        dflt_mode = v.dm;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R2: reset clears outputs even with a request present.
        drive(VECS[4]);
        repeat (3) @(negedge clk);
        chk("R2", "reset out_valid", 32'(out_valid), 32'h0);
        chk("R2", "reset out_result", out_result, 32'h0);
        chk("R2", "reset out_invalid", 32'(out_invalid), 32'h0);
        chk("R2", "reset out_choice", 32'(out_choice), 32'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "idle out_valid", 32'(out_valid), 32'h0);

        // Table walk, one request per cycle.
        drive(VECS[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            begin
                string tag;
                tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
                chk(tag, "out_valid", 32'(out_valid), 32'h1);
                chk(tag, "out_hit", 32'(out_hit), 32'(VECS[i].hit));
                chk(tag, "out_choice", 32'(out_choice), 32'(VECS[i].ch));
                chk(tag, "out_result", out_result, VECS[i].res);
                chk(tag, "out_invalid", 32'(out_invalid), 32'(VECS[i].iv));
            end
            if (i + 1 < NV) drive(VECS[i + 1]);
            else            in_valid = 1'b0;
        end

        // R2: without a request the data must not move.
        op_a = LA; op_b = LB; op_c = LC; policy = 2'd0; snan_inv = 1'b0; dflt_mode = 1'b0;
        @(negedge clk);
        chk("R2", "hold out_valid", 32'(out_valid), 32'h0);
        chk("R2", "hold out_result", out_result, VECS[NV-1].res);
        chk("R2", "hold out_invalid", 32'(out_invalid), 32'h0);
        @(negedge clk);
        chk("R2", "hold2 out_result", out_result, VECS[NV-1].res);

        // R1: a NaN with only bit 22 set is quiet at normal polarity.
        drive('{DN, ONE, ONE, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, DN, 1'b0, 4'd1});
        @(negedge clk);
        chk("R1", "mark-only quiet result", out_result, DN);
        chk("R1", "mark-only quiet invalid", 32'(out_invalid), 32'h0);

        // R2: reset in the middle of a run clears the outputs.
        drive(VECS[7]);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2", "mid reset out_valid", 32'(out_valid), 32'h0);
        chk("R2", "mid reset out_result", out_result, 32'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule